// File: doc/BRIEF.md
# Codec Parameter Loader and Framer

This block sits on the byte-wide input of a programmable Reed-Solomon codec. After reset, the data bus first carries a six-byte configuration preamble. The block stores those bytes and checks that they form a legal code. It then treats every later qualified byte as payload and cuts the stream into code blocks of N bytes. Each block holds K message bytes followed by R check-byte slots.

Every payload byte comes out one clock later. It carries its position inside the block, a flag that marks check slots, start-of-block and end-of-block markers, and the operating mode and format bits taken from the control byte. Blocks follow one another without limit until the next reset. A parameter set that breaks the code rules locks the block into a fault state, and it then passes no payload at all.

Top module: `rs_ingest_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, cfg_ready and cfg_error are all 0.
- R2: The first six bytes taken with in_valid high after reset are configuration, taken in this order: erasure multiplier, error threshold, R, K, N, control. They appear on par_mult, par_thresh, par_r, par_k, par_n and par_ctrl. No configuration byte raises out_valid, and clocks with in_valid low do not advance the sequence.
- R3: If the set is legal, cfg_ready is 1 from the clock edge that takes the sixth byte. A legal set has R even and in 2..20, N of at least 3, K+R equal to N (the sum is taken in 9 bits, so it cannot wrap), and control bits [1:0] not equal to 3.
- R4: An illegal set raises cfg_error from the clock edge that takes the sixth byte. cfg_error stays high and cfg_ready stays 0 until reset, and no later byte raises out_valid.
- R5: In the ready state, a byte taken with in_valid high shows on out_byte with out_valid high in the next cycle. out_valid is low in every other cycle.
- R6: out_pos counts 0 to N-1 over the accepted payload bytes and then wraps to 0. Any number of consecutive blocks is framed with no further programming.
- R7: out_check is 1 exactly when out_pos is K or more.
- R8: out_sob is 1 exactly when out_pos is 0, and out_eob is 1 exactly when out_pos is N-1.
- R9: out_mode equals control bits [1:0] (0 decode, 1 encode, 2 pass-through), and out_fmt equals control bits [7:2].
- R10: A reset in the middle of a run clears the configuration. The next six qualified bytes are then taken as a new preamble and are not passed as payload.
- R11: Cycles with in_valid low in the ready state leave out_pos unchanged for the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_byte |
| in_byte | input | 8 | Configuration or payload byte |
| out_valid | output | 1 | Payload byte present on the outputs |
| out_byte | output | 8 | Payload byte, one cycle after acceptance |
| out_pos | output | 8 | Byte position within the block |
| out_check | output | 1 | Byte occupies a check slot |
| out_sob | output | 1 | First byte of a block |
| out_eob | output | 1 | Last byte of a block |
| out_mode | output | 2 | Operating mode from control byte |
| out_fmt | output | 6 | Output-format bits from control byte |
| cfg_ready | output | 1 | Legal configuration loaded |
| cfg_error | output | 1 | Illegal configuration, payload blocked |
| par_mult | output | 8 | Stored erasure multiplier |
| par_thresh | output | 8 | Stored error threshold |
| par_r | output | 8 | Stored number of check bytes |
| par_k | output | 8 | Stored number of message bytes |
| par_n | output | 8 | Stored block length |
| par_ctrl | output | 8 | Stored control byte |

## Verification
The properties assume that in_byte and in_valid settle well away from the rising edge. They also assume that the parameter outputs hold a legal set whenever cfg_ready is high, so N-1 and K are meaningful for the end-of-block and check-slot relations. The stimulus changes inputs only on the falling edge and applies reset before each preamble. It feeds legal sets at both ends of the N and R ranges, and it feeds illegal sets one at a time. One of those is a K+R sum that would wrap to N in eight bits. Gaps in in_valid occur during both the preamble and the payload.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FAULT = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    MODE_DECODE = 2'd0,
    MODE_ENCODE = 2'd1,
    MODE_PASS   = 2'd2,
    MODE_BAD    = 2'd3
  } mode_t;

  // slot order of the preamble; the sequence is behaviour
  localparam int unsigned SLOT_MULT   = 0;
  localparam int unsigned SLOT_THRESH = 1;
  localparam int unsigned SLOT_CHK    = 2;
  localparam int unsigned SLOT_MSG    = 3;
  localparam int unsigned SLOT_LEN    = 4;
  localparam int unsigned SLOT_CTRL   = 5;
  localparam int unsigned SLOT_COUNT  = 6;

endpackage

// File: rtl/rsf_cfg_capture.sv
module rsf_cfg_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take,
  input  logic [DATA_W-1:0]              byte_in,
  output logic [SLOTS-1:0][DATA_W-1:0]   slot_q,
  output logic [SLOTS-1:0][DATA_W-1:0]   slot_m,
  output logic                           last_take
);
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  assign last_take = take && (idx_q == IDX_LAST);

  always_comb begin
    idx_d = idx_q;
    if (take) begin
      if (idx_q == IDX_LAST) idx_d = '0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // one storage register per preamble slot, each with its own enable
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] r_q;
    logic              en;
    assign en = take && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r_q <= '0;
      else if (en) r_q <= byte_in;
    end
    assign slot_q[g] = r_q;
    // view of the set including the byte taken this cycle
    assign slot_m[g] = en ? byte_in : r_q;
  end

endmodule

// File: rtl/rsf_param_check.sv
module rsf_param_check #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned R_MIN  = 2,
  parameter int unsigned R_MAX  = 20,
  parameter int unsigned N_MIN  = 3
) (
  input  logic [DATA_W-1:0] r_cnt,
  input  logic [DATA_W-1:0] k_cnt,
  input  logic [DATA_W-1:0] n_len,
  input  logic [DATA_W-1:0] ctrl,
  output logic              legal
);
  import rsf_pkg::*;

  logic [DATA_W:0] kr_sum;
  logic            r_even;
  logic            r_in_range;
  logic            n_long;
  logic            sum_ok;
  logic            mode_ok;

  always_comb begin
    kr_sum     = {1'b0, k_cnt} + {1'b0, r_cnt};
    r_even     = ~r_cnt[0];
    r_in_range = (r_cnt >= DATA_W'(R_MIN)) && (r_cnt <= DATA_W'(R_MAX));
    n_long     = (n_len >= DATA_W'(N_MIN));
    sum_ok     = (kr_sum == {1'b0, n_len});
    mode_ok    = (mode_t'(ctrl[1:0]) != MODE_BAD);
    legal      = r_even && r_in_range && n_long && sum_ok && mode_ok;
  end

endmodule

// File: rtl/rsf_phase_ctl.sv
module rsf_phase_ctl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            last_take,
  input  logic            legal,
  output rsf_pkg::phase_t phase
);
  import rsf_pkg::*;

  phase_t ph_q;
  phase_t ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_LOAD:  if (last_take) ph_d = legal ? PH_RUN : PH_FAULT;
      PH_RUN:   ph_d = PH_RUN;
      PH_FAULT: ph_d = PH_FAULT;
      default:  ph_d = PH_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_LOAD;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

endmodule

// File: rtl/rsf_block_counter.sv
module rsf_block_counter #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [POS_W-1:0] n_len,
  input  logic [POS_W-1:0] k_cnt,
  output logic [POS_W-1:0] pos,
  output logic             at_first,
  output logic             at_last,
  output logic             in_check
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    at_first = (pos_q == '0);
    at_last  = (pos_q == (n_len - 1'b1));
    in_check = (pos_q >= k_cnt);
    pos_d    = pos_q;
    if (step) begin
      if (at_last) pos_d = '0;
      else         pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/rsf_out_stage.sv
module rsf_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] pos_in,
  input  logic              check_in,
  input  logic              first_in,
  input  logic              last_in,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_byte,
  output logic [DATA_W-1:0] o_pos,
  output logic              o_check,
  output logic              o_sob,
  output logic              o_eob
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_valid <= 1'b0;
    else        o_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_byte  <= '0;
      o_pos   <= '0;
      o_check <= 1'b0;
      o_sob   <= 1'b0;
      o_eob   <= 1'b0;
    end else if (fire) begin
      o_byte  <= byte_in;
      o_pos   <= pos_in;
      o_check <= check_in;
      o_sob   <= first_in;
      o_eob   <= last_in;
    end
  end

endmodule

// File: rtl/rs_ingest_framer.sv
module rs_ingest_framer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned R_MIN  = 2,
  parameter int unsigned R_MAX  = 20,
  parameter int unsigned N_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic [DATA_W-1:0] out_pos,
  output logic              out_check,
  output logic              out_sob,
  output logic              out_eob,
  output logic [1:0]        out_mode,
  output logic [DATA_W-3:0] out_fmt,
  output logic              cfg_ready,
  output logic              cfg_error,
  output logic [DATA_W-1:0] par_mult,
  output logic [DATA_W-1:0] par_thresh,
  output logic [DATA_W-1:0] par_r,
  output logic [DATA_W-1:0] par_k,
  output logic [DATA_W-1:0] par_n,
  output logic [DATA_W-1:0] par_ctrl
);
  import rsf_pkg::*;

  localparam int unsigned SLOTS = SLOT_COUNT;

  phase_t                        phase;
  logic                          take_cfg;
  logic                          fire;
  logic                          last_take;
  logic                          legal;
  logic [SLOTS-1:0][DATA_W-1:0]  slot_q;
  logic [SLOTS-1:0][DATA_W-1:0]  slot_m;
  logic [DATA_W-1:0]             pos;
  logic                          at_first;
  logic                          at_last;
  logic                          in_check;

  assign take_cfg = in_valid && (phase == PH_LOAD);
  assign fire     = in_valid && (phase == PH_RUN);

  rsf_cfg_capture #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_cfg),
    .byte_in   (in_byte),
    .slot_q    (slot_q),
    .slot_m    (slot_m),
    .last_take (last_take)
  );

  rsf_param_check #(
    .DATA_W(DATA_W), .R_MIN(R_MIN), .R_MAX(R_MAX), .N_MIN(N_MIN)
  ) u_chk_par (
    .r_cnt (slot_m[SLOT_CHK]),
    .k_cnt (slot_m[SLOT_MSG]),
    .n_len (slot_m[SLOT_LEN]),
    .ctrl  (slot_m[SLOT_CTRL]),
    .legal (legal)
  );

  rsf_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_take (last_take),
    .legal     (legal),
    .phase     (phase)
  );

  rsf_block_counter #(.POS_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fire),
    .n_len    (slot_q[SLOT_LEN]),
    .k_cnt    (slot_q[SLOT_MSG]),
    .pos      (pos),
    .at_first (at_first),
    .at_last  (at_last),
    .in_check (in_check)
  );

  rsf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .byte_in  (in_byte),
    .pos_in   (pos),
    .check_in (in_check),
    .first_in (at_first),
    .last_in  (at_last),
    .o_valid  (out_valid),
    .o_byte   (out_byte),
    .o_pos    (out_pos),
    .o_check  (out_check),
    .o_sob    (out_sob),
    .o_eob    (out_eob)
  );

  assign cfg_ready  = (phase == PH_RUN);
  assign cfg_error  = (phase == PH_FAULT);
  assign par_mult   = slot_q[SLOT_MULT];
  assign par_thresh = slot_q[SLOT_THRESH];
  assign par_r      = slot_q[SLOT_CHK];
  assign par_k      = slot_q[SLOT_MSG];
  assign par_n      = slot_q[SLOT_LEN];
  assign par_ctrl   = slot_q[SLOT_CTRL];
  assign out_mode   = slot_q[SLOT_CTRL][1:0];
  assign out_fmt    = slot_q[SLOT_CTRL][DATA_W-1:2];

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_byte,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_byte,
  input logic [DATA_W-1:0] out_pos,
  input logic              out_check,
  input logic              out_sob,
  input logic              out_eob,
  input logic              cfg_ready,
  input logic              cfg_error,
  input logic [DATA_W-1:0] par_k,
  input logic [DATA_W-1:0] par_n
);
  // R5: accepted payload byte emerges one cycle later
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && in_valid) |=> (out_valid && out_byte == $past(in_byte)));

  // R5: nothing comes out unless a ready-state byte was taken
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ready && in_valid) |=> !out_valid);

  // R4: fault state is sticky and silent
  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> (cfg_error && !cfg_ready));

  a_r4_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !out_valid);

  // R3: ready is never withdrawn until reset
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);

  // R8: markers sit on the block boundaries
  a_r8_eob_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eob) |-> (out_pos == par_n - 1'b1));

  a_r8_sob_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sob) |-> (out_pos == '0));

  // R7: check-slot flag agrees with the stored message length
  a_r7_check_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_check == (out_pos >= par_k)));

  // R6: position never reaches the block length
  a_r6_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pos < par_n));

endmodule

bind rs_ingest_framer rsf_checker #(.DATA_W(DATA_W)) u_rsf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_byte   (in_byte),
  .out_valid (out_valid),
  .out_byte  (out_byte),
  .out_pos   (out_pos),
  .out_check (out_check),
  .out_sob   (out_sob),
  .out_eob   (out_eob),
  .cfg_ready (cfg_ready),
  .cfg_error (cfg_error),
  .par_k     (par_k),
  .par_n     (par_n)
);

// File: tb/rs_ingest_framer_test.sv
`timescale 1ns/1ps
module rs_ingest_framer_test;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [7:0] out_pos;
  logic       out_check;
  logic       out_sob;
  logic       out_eob;
  logic [1:0] out_mode;
  logic [5:0] out_fmt;
  logic       cfg_ready;
  logic       cfg_error;
  logic [7:0] par_mult, par_thresh, par_r, par_k, par_n, par_ctrl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the stored configuration
  int m_n, m_k;
  int m_pos;

  rs_ingest_framer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_pos(out_pos),
    .out_check(out_check), .out_sob(out_sob), .out_eob(out_eob),
    .out_mode(out_mode), .out_fmt(out_fmt),
    .cfg_ready(cfg_ready), .cfg_error(cfg_error),
    .par_mult(par_mult), .par_thresh(par_thresh), .par_r(par_r),
    .par_k(par_k), .par_n(par_n), .par_ctrl(par_ctrl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // leaves the bench at a falling edge
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_pos = 0;
  endtask

  task automatic load_cfg(input int mult, input int thr, input int r,
                          input int k, input int n, input int ctrl,
                          input bit gaps);
    int vals[6];
    vals = '{mult, thr, r, k, n, ctrl};
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_byte = vals[i][7:0];
      @(negedge clk);
      in_valid = 1'b0;
      chk(!out_valid, "R2", "config byte raised out_valid", out_valid, 0);
      if (gaps) begin
        @(negedge clk);
        if (i < 5) chk(!cfg_ready && !cfg_error, "R2", "gap changed status",
                       {cfg_ready, cfg_error}, 0);
      end
    end
    m_n = n; m_k = k; m_pos = 0;
  endtask

  // streams bytes, checking each result in the cycle after acceptance
  task automatic stream(input int count, input int seed, input int gap_every);
    for (int i = 0; i < count; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) & 8'hff);
      in_valid = 1'b1; in_byte = b;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b1, "R5", "out_valid", out_valid, 1);
      chk(out_byte == b, "R5", "out_byte", out_byte, b);
      chk(out_pos == m_pos[7:0], "R6", "out_pos", out_pos, m_pos);
      chk(out_check == (m_pos >= m_k), "R7", "out_check", out_check, m_pos >= m_k);
      chk(out_sob == (m_pos == 0), "R8", "out_sob", out_sob, m_pos == 0);
      chk(out_eob == (m_pos == m_n - 1), "R8", "out_eob", out_eob, m_pos == m_n - 1);
      m_pos = (m_pos == m_n - 1) ? 0 : m_pos + 1;
      if (gap_every != 0 && (i % gap_every) == 0) begin
        repeat (2) @(negedge clk);
        chk(!out_valid, "R11", "out_valid during gap", out_valid, 0);
      end
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    @(negedge clk);
    chk(!out_valid && !cfg_ready && !cfg_error, "R1", "status in reset",
        {out_valid, cfg_ready, cfg_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !cfg_ready && !cfg_error, "R1", "status after reset",
        {out_valid, cfg_ready, cfg_error}, 0);
  endtask

  task automatic t_legal_encode();
    do_reset();
    load_cfg(8'h11, 8'h22, 4, 6, 10, {6'h2b, 2'b01}, 1'b1);
    chk(cfg_ready && !cfg_error, "R3", "ready after legal set", cfg_ready, 1);
    chk(par_mult == 8'h11, "R2", "par_mult", par_mult, 8'h11);
    chk(par_thresh == 8'h22, "R2", "par_thresh", par_thresh, 8'h22);
    chk(par_r == 4 && par_k == 6 && par_n == 10, "R2", "par r/k/n",
        {par_r, par_k, par_n}, {8'd4, 8'd6, 8'd10});
    chk(par_ctrl == {6'h2b, 2'b01}, "R2", "par_ctrl", par_ctrl, {6'h2b, 2'b01});
    chk(out_mode == 2'b01, "R9", "out_mode encode", out_mode, 1);
    chk(out_fmt == 6'h2b, "R9", "out_fmt", out_fmt, 6'h2b);
    stream(25, 3, 0);
    stream(12, 90, 3);
  endtask

  task automatic t_illegal(input int r, input int k, input int n,
                           input int ctrl, input string what);
    do_reset();
    load_cfg(1, 2, r, k, n, ctrl, 1'b0);
    chk(cfg_error && !cfg_ready, "R4", what, {cfg_error, cfg_ready}, 2);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_byte = 8'(i + 5);
      @(negedge clk);
      in_valid = 1'b0;
      chk(!out_valid && cfg_error, "R4", "payload after fault",
          {out_valid, cfg_error}, 1);
    end
  endtask

  task automatic t_long_block();
    do_reset();
    load_cfg(0, 0, 20, 235, 255, {6'h00, 2'b00}, 1'b0);
    chk(cfg_ready, "R3", "ready for N=255", cfg_ready, 1);
    chk(out_mode == 2'b00, "R9", "out_mode decode", out_mode, 0);
    stream(258, 7, 0);
  endtask

  task automatic t_short_block();
    do_reset();
    load_cfg(3, 4, 2, 1, 3, {6'h15, 2'b10}, 1'b1);
    chk(cfg_ready, "R3", "ready for N=3", cfg_ready, 1);
    chk(out_mode == 2'b10 && out_fmt == 6'h15, "R9", "pass-through mode/fmt",
        {out_mode, out_fmt}, {2'b10, 6'h15});
    stream(7, 200, 2);
  endtask

  task automatic t_reset_midrun();
    do_reset();
    load_cfg(5, 6, 2, 3, 5, {6'h01, 2'b01}, 1'b0);
    stream(3, 11, 0);
    do_reset();
    chk(!cfg_ready && !cfg_error, "R10", "config cleared", cfg_ready, 0);
    load_cfg(9, 8, 6, 2, 8, {6'h3f, 2'b00}, 1'b0);
    chk(cfg_ready, "R10", "new preamble accepted", cfg_ready, 1);
    chk(par_n == 8 && par_k == 2 && par_mult == 9, "R10", "new parameters",
        par_n, 8);
    stream(9, 44, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    t_reset_state();
    t_legal_encode();
    t_illegal(5, 5, 10, 1, "odd R");
    t_illegal(22, 10, 32, 1, "R above 20");
    t_illegal(0, 10, 10, 1, "R zero");
    t_illegal(2, 0, 2, 1, "N below 3");
    t_illegal(4, 6, 11, 1, "K+R not N");
    t_illegal(10, 250, 4, 1, "K+R wraps in 8 bits");
    t_illegal(4, 6, 10, 3, "mode 3");
    t_long_block();
    t_short_block();
    t_reset_midrun();
    finish_run();
  end

endmodule